// File: doc/BRIEF.md
# Cumulative Overtemperature Assertion Timer

This block keeps a running total of how long an active-low overtemperature line has been held low, and raises a status flag and an active-low alert once that total reaches a programmable limit. The line may be pulled low by the block itself when a local temperature comparator reports an over-limit condition (bidirectional mode), by some external device, or by both. The total is kept in a saturating register that software reads; the read clears it. Short assertions separated in time still add up, because the fractional part of a count step is kept between events.

A prescaled `tick` input sets the time base. `TICKS_PER_LSB` ticks of asserted time make one step of the accumulated-time register. One step of the limit value equals two register steps. A fan boost request for fans that are already running is also produced while the line is low.

Top module: `ot_accum_timer`

## Requirements
- R1: After reset, `acc_time` is 0, `stat` is 0, `alert_n` is 1, `line_pull` is 0 and `fan_boost` is all zeros.
- R2: Time is accumulated only while both `timer_en` and `pin_timer_sel` are 1. With either at 0, ticks during an assertion leave `acc_time` unchanged.
- R3: The line counts as asserted when `line_n` is 0 after a two-flop synchronizer. Every `TICKS_PER_LSB` (default 4) ticks seen while it is asserted add 1 to `acc_time`. Leftover ticks from one assertion carry into the next assertion.
- R4: `acc_time` saturates at all ones (255 by default) and does not wrap.
- R5: A one-cycle `rd_acc` pulse clears `acc_time` to 0. If a register step completes in the same cycle as the read, `acc_time` becomes 1 instead.
- R6: When `bidir_sel` is non-zero and `pin_timer_sel` is 1, `line_pull` is 1 whenever `local_over` is 1. Assertions driven by an external device while `line_pull` is 0 are accumulated too.
- R7: When `bidir_sel` is 3'b000, `line_pull` stays 0 whatever `local_over` is.
- R8: With `limit` equal to 0, `stat` becomes 1 on the first assertion of the line while timing is enabled.
- R9: With `limit` equal to L (non-zero), `stat` becomes 1 once `acc_time` is at least 2*L, and not before.
- R10: When `alert_mask` is 1, `alert_n` stays 1 while `stat` is still set. Clearing the mask lets `alert_n` go to 0 while `stat` is 1.
- R11: `stat` stays at 1 until a `stat_clr` pulse. That pulse drops `stat` and returns `alert_n` to 1. If the trip condition still holds in that cycle, `stat` stays set.
- R12: While `boost_en` is 1, `pin_timer_sel` is 1 and the line is asserted, `fan_boost[i]` equals `fan_running[i]`. With `boost_en` at 0, or with the line released, `fan_boost` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_n | input | 1 | Sampled level of the overtemperature line, low = asserted |
| local_over | input | 1 | Local temperature comparator over-limit flag |
| tick | input | 1 | Prescaled time-base pulse, one cycle wide |
| timer_en | input | 1 | Timer enable configuration bit |
| pin_timer_sel | input | 1 | Pin configured for the timer function |
| bidir_sel | input | 3 | Bidirectional-mode select bits; all zero = input only |
| boost_en | input | 1 | Fan boost on line assertion enable |
| limit | input | LIM_W | Cumulative time limit, in steps of two register LSBs |
| alert_mask | input | 1 | Suppresses the alert output when 1 |
| rd_acc | input | 1 | Read strobe for the accumulated-time register (clears it) |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| fan_running | input | NUM_FANS | Per-fan indication that the fan is currently spinning |
| line_pull | output | 1 | Pull-down enable for the overtemperature line |
| acc_time | output | ACC_W | Accumulated asserted time |
| stat | output | 1 | Sticky limit-exceeded status |
| alert_n | output | 1 | Active-low alert |
| fan_boost | output | NUM_FANS | Full-duty request per fan |

## Verification
The accumulator is driven with a single long assertion, with several short assertions that leave partial steps behind, with ticks arriving while the line is released or timing is disabled, and with a read that coincides with a completed step. Together these separate a correct fractional carry from a counter that resets per event or counts idle time. Limit behaviour is tried at zero (first-assertion trip) and at a non-zero value, stepping one tick across the threshold to show that the limit is twice the register resolution. Self-driven and externally driven assertions in bidirectional mode are contrasted with input-only mode, so that the pull-down and the counting can be told apart.

// File: rtl/ot_pkg.sv
package ot_pkg;

    // Depth of the line synchronizer
    localparam int SYNC_STAGES = 2;

    // Decoded configuration that the datapath works from
    typedef struct packed {
        logic active;   // timing enabled and pin in timer function
        logic bidir;    // block may pull the line low
        logic boost;    // boost allowed on assertions
    } ot_mode_t;

    function automatic ot_mode_t decode_mode(input logic en, input logic pin,
                                             input logic [2:0] bsel, input logic boost_en);
        ot_mode_t m;
        m.active = en & pin;
        m.bidir  = pin & (|bsel);
        m.boost  = pin & boost_en;
        return m;
    endfunction

endpackage

// File: rtl/ot_line_sync.sv
module ot_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_n,
    output logic q_n
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[STAGES-2:0], d_n};
    end

    assign q_n = shreg[STAGES-1];
endmodule

// File: rtl/ot_accum.sv
module ot_accum #(
    parameter int ACC_W         = 8,
    parameter int TICKS_PER_LSB = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             rd,
    output logic [ACC_W-1:0] acc
);
    logic step;

    generate
        if (TICKS_PER_LSB > 1) begin : g_sub
            localparam int SUB_W = $clog2(TICKS_PER_LSB);
            localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_LSB - 1);
            logic [SUB_W-1:0] sub_q;

            assign step = count_en && (sub_q == SUB_LAST);

            // partial step survives between separate assertions
            always_ff @(posedge clk) begin
                if (rst)           sub_q <= '0;
                else if (count_en) sub_q <= step ? '0 : sub_q + 1'b1;
            end
        end else begin : g_direct
            assign step = count_en;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                  acc <= '0;
        else if (rd)              acc <= step ? ACC_W'(1) : '0;
        else if (step && acc != '1) acc <= acc + 1'b1;
    end
endmodule

// File: rtl/ot_alert.sv
module ot_alert #(
    parameter int ACC_W = 8,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             asserted,
    input  logic [ACC_W-1:0] acc,
    input  logic [LIM_W-1:0] limit,
    input  logic             mask,
    input  logic             clr,
    output logic             stat,
    output logic             alert_n
);
    localparam int CW = (ACC_W > LIM_W + 1) ? ACC_W : LIM_W + 1;

    logic [CW-1:0] acc_x;
    logic [CW-1:0] lim_x;
    logic          trip;

    assign acc_x = CW'(acc);
    assign lim_x = CW'({limit, 1'b0});   // one limit step = two register steps

    always_comb begin
        if (!active)          trip = 1'b0;
        else if (limit == '0) trip = asserted;
        else                  trip = (acc_x >= lim_x);
    end

    // set has priority over the write-one-to-clear strobe
    always_ff @(posedge clk) begin
        if (rst)       stat <= 1'b0;
        else if (trip) stat <= 1'b1;
        else if (clr)  stat <= 1'b0;
    end

    assign alert_n = ~(stat & ~mask);
endmodule

// File: rtl/ot_accum_timer.sv
module ot_accum_timer #(
    parameter int ACC_W         = 8,
    parameter int LIM_W         = 8,
    parameter int TICKS_PER_LSB = 4,
    parameter int NUM_FANS      = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_n,
    input  logic                local_over,
    input  logic                tick,
    input  logic                timer_en,
    input  logic                pin_timer_sel,
    input  logic [2:0]          bidir_sel,
    input  logic                boost_en,
    input  logic [LIM_W-1:0]    limit,
    input  logic                alert_mask,
    input  logic                rd_acc,
    input  logic                stat_clr,
    input  logic [NUM_FANS-1:0] fan_running,
    output logic                line_pull,
    output logic [ACC_W-1:0]    acc_time,
    output logic                stat,
    output logic                alert_n,
    output logic [NUM_FANS-1:0] fan_boost
);
    import ot_pkg::*;

    ot_mode_t mode;
    logic     line_s_n;
    logic     asserted;
    logic     active;

    assign mode     = decode_mode(timer_en, pin_timer_sel, bidir_sel, boost_en);
    assign active   = mode.active;
    assign asserted = ~line_s_n;

    ot_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_n (line_n),
        .q_n (line_s_n)
    );

    ot_accum #(.ACC_W(ACC_W), .TICKS_PER_LSB(TICKS_PER_LSB)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .count_en (active & asserted & tick),
        .rd       (rd_acc),
        .acc      (acc_time)
    );

    ot_alert #(.ACC_W(ACC_W), .LIM_W(LIM_W)) u_alert (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .asserted (asserted),
        .acc      (acc_time),
        .limit    (limit),
        .mask     (alert_mask),
        .clr      (stat_clr),
        .stat     (stat),
        .alert_n  (alert_n)
    );

    assign line_pull = mode.bidir & local_over;

    generate
        for (genvar f = 0; f < NUM_FANS; f++) begin : g_fan
            assign fan_boost[f] = mode.boost & asserted & fan_running[f];
        end
    endgenerate
endmodule

// File: rtl/ot_accum_timer_chk.sv
module ot_accum_timer_chk #(
    parameter int ACC_W    = 8,
    parameter int NUM_FANS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                active,
    input logic [2:0]          bidir_sel,
    input logic                line_pull,
    input logic                rd_acc,
    input logic [ACC_W-1:0]    acc_time,
    input logic                stat,
    input logic                stat_clr,
    input logic                alert_mask,
    input logic                alert_n,
    input logic                boost_en,
    input logic [NUM_FANS-1:0] fan_boost
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !rd_acc) |=> (acc_time == $past(acc_time)));

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_time == '1 && !rd_acc) |=> (acc_time == '1));

    // R7
    input_only_chk: assert property (@(posedge clk) disable iff (rst)
        (bidir_sel == 3'b000) |-> !line_pull);

    // R8
    trip_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat) |-> $past(active));

    // R10
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        alert_mask |-> alert_n);

    // R11
    sticky_stat_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stat) |-> $past(stat_clr));

    // R12
    boost_off_chk: assert property (@(posedge clk) disable iff (rst)
        !boost_en |-> (fan_boost == '0));
endmodule

bind ot_accum_timer ot_accum_timer_chk #(.ACC_W(ACC_W), .NUM_FANS(NUM_FANS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .bidir_sel  (bidir_sel),
    .line_pull  (line_pull),
    .rd_acc     (rd_acc),
    .acc_time   (acc_time),
    .stat       (stat),
    .stat_clr   (stat_clr),
    .alert_mask (alert_mask),
    .alert_n    (alert_n),
    .boost_en   (boost_en),
    .fan_boost  (fan_boost)
);

// File: tb/ot_accum_timer_bench.sv
module ot_accum_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       ext_low;
    logic       line_n;
    logic       local_over, tick, timer_en, pin_timer_sel, boost_en;
    logic [2:0] bidir_sel;
    logic [7:0] limit;
    logic       alert_mask, rd_acc, stat_clr;
    logic [3:0] fan_running;
    logic       line_pull, stat, alert_n;
    logic [7:0] acc_time;
    logic [3:0] fan_boost;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // wired-low line: external device or the block itself
    assign line_n = !(ext_low | line_pull);

    ot_accum_timer u_ot_accum_timer (
        .clk(clk), .rst(rst), .line_n(line_n), .local_over(local_over), .tick(tick),
        .timer_en(timer_en), .pin_timer_sel(pin_timer_sel), .bidir_sel(bidir_sel),
        .boost_en(boost_en), .limit(limit), .alert_mask(alert_mask), .rd_acc(rd_acc),
        .stat_clr(stat_clr), .fan_running(fan_running), .line_pull(line_pull),
        .acc_time(acc_time), .stat(stat), .alert_n(alert_n), .fan_boost(fan_boost)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic read_acc(input logic with_tick);
        @(negedge clk) begin rd_acc = 1'b1; tick = with_tick; end
        @(negedge clk) begin rd_acc = 1'b0; tick = 1'b0; end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; ext_low = 1'b0; local_over = 1'b0; tick = 1'b0;
        timer_en = 1'b1; pin_timer_sel = 1'b1; bidir_sel = 3'b000; boost_en = 1'b0;
        limit = 8'hFF; alert_mask = 1'b1; rd_acc = 1'b0; stat_clr = 1'b0;
        fan_running = 4'b0000;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(1);
    endtask

    task automatic t_reset_state;
        do_reset();
        check("R1 acc_time", acc_time, 0);
        check("R1 stat", stat, 0);
        check("R1 alert_n", alert_n, 1);
        check("R1 line_pull", line_pull, 0);
        check("R1 fan_boost", fan_boost, 0);
    endtask

    task automatic t_disabled;
        do_reset();
        timer_en = 1'b0;
        ext_low = 1'b1;
        wait_cyc(3);
        tick_n(8);
        check("R2 timer_en=0", acc_time, 0);
        timer_en = 1'b1; pin_timer_sel = 1'b0;
        tick_n(8);
        check("R2 pin_timer_sel=0", acc_time, 0);
    endtask

    task automatic t_accumulate;
        do_reset();
        ext_low = 1'b1;
        wait_cyc(3);
        tick_n(6);
        check("R3 six ticks", acc_time, 1);
        ext_low = 1'b0;
        wait_cyc(3);
        tick_n(4);
        check("R3 released line ignored", acc_time, 1);
        ext_low = 1'b1;
        wait_cyc(3);
        tick_n(2);
        check("R3 partial carried", acc_time, 2);
        read_acc(1'b0);
        check("R5 read clears", acc_time, 0);
        tick_n(3);
        check("R3 three ticks no step", acc_time, 0);
        read_acc(1'b1);
        check("R5 read with step", acc_time, 1);
    endtask

    task automatic t_saturate;
        do_reset();
        ext_low = 1'b1;
        wait_cyc(3);
        tick_n(4 * 256 + 8);
        check("R4 saturated", acc_time, 255);
        read_acc(1'b0);
        check("R5 clear after saturation", acc_time, 0);
    endtask

    task automatic t_limit;
        do_reset();
        limit = 8'd2; alert_mask = 1'b0;
        ext_low = 1'b1;
        wait_cyc(3);
        tick_n(15);
        wait_cyc(1);
        check("R9 below limit acc", acc_time, 3);
        check("R9 below limit stat", stat, 0);
        check("R9 below limit alert_n", alert_n, 1);
        tick_n(1);
        wait_cyc(1);
        check("R9 at limit stat", stat, 1);
        check("R9 at limit alert_n", alert_n, 0);
        ext_low = 1'b0;
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
        check("R11 set wins over clear", stat, 1);
        read_acc(1'b0);
        check("R11 still sticky after read", stat, 1);
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
        check("R11 cleared stat", stat, 0);
        check("R11 cleared alert_n", alert_n, 1);
    endtask

    task automatic t_limit_zero;
        do_reset();
        limit = 8'd0; alert_mask = 1'b0;
        wait_cyc(3);
        check("R8 no trip while idle", stat, 0);
        ext_low = 1'b1;
        wait_cyc(4);
        check("R8 first assertion stat", stat, 1);
        check("R8 first assertion alert_n", alert_n, 0);
    endtask

    task automatic t_mask;
        do_reset();
        limit = 8'd0; alert_mask = 1'b1;
        ext_low = 1'b1;
        wait_cyc(4);
        check("R10 masked stat", stat, 1);
        check("R10 masked alert_n", alert_n, 1);
        alert_mask = 1'b0;
        wait_cyc(1);
        check("R10 unmasked alert_n", alert_n, 0);
    endtask

    task automatic t_bidir;
        do_reset();
        bidir_sel = 3'b111; local_over = 1'b1;
        wait_cyc(3);
        check("R6 self pull", line_pull, 1);
        tick_n(4);
        check("R6 self assertion counted", acc_time, 1);
        local_over = 1'b0; ext_low = 1'b1;
        wait_cyc(3);
        check("R6 pull released", line_pull, 0);
        tick_n(4);
        check("R6 external assertion counted", acc_time, 2);
        ext_low = 1'b0; bidir_sel = 3'b000; local_over = 1'b1;
        wait_cyc(3);
        check("R7 input-only no pull", line_pull, 0);
        tick_n(4);
        check("R7 input-only no count", acc_time, 2);
    endtask

    task automatic t_boost;
        do_reset();
        boost_en = 1'b1; fan_running = 4'b0101;
        wait_cyc(3);
        check("R12 idle line no boost", fan_boost, 0);
        ext_low = 1'b1;
        wait_cyc(3);
        check("R12 running fans boosted", fan_boost, 5);
        boost_en = 1'b0;
        wait_cyc(1);
        check("R12 boost disabled", fan_boost, 0);
    endtask

    initial begin
        rst = 1'b1;
        t_reset_state();
        t_disabled();
        t_accumulate();
        t_saturate();
        t_limit();
        t_limit_zero();
        t_mask();
        t_bidir();
        t_boost();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule